// File: doc/BRIEF.md
# Bidirectional Loadable Shift Register

This block holds a small word that can be cleared, loaded in parallel, shifted toward its most significant bit or shifted toward its least significant bit, one action per rising clock edge. Each shift direction takes its new bit from a serial input of its own. The bit shifted off the far end is dropped.

Control follows a fixed priority. A synchronous clear wins over everything. A parallel load comes next and does not need the shift enable. A shift happens only when the enable is high, and its direction comes from the direction select. With none of these, the word holds. The word reads as zero from power-up, before any clock edge, without a reset pin for that purpose.

Top module: `bidir_shreg`

## Requirements
- R1: When `sync_clr` is 1 at a rising edge, `word_out` becomes all zeros after that edge, whatever the other inputs are.
- R2: When `sync_clr` is 0 and `par_load` is 1 at a rising edge, `word_out` takes `par_in` bit for bit after that edge, whether `shift_en` is 0 or 1.
- R3: When `sync_clr`, `par_load` and `shift_en` are all 0 at a rising edge, `word_out` keeps its value, and the serial and parallel inputs have no effect.
- R4: When `shift_en` is 1, `sync_clr` and `par_load` are 0 and `dir_up` is 1, bit i of the new word is old bit i-1, bit 0 takes `ser_in_up`, and the old top bit is dropped.
- R5: When `shift_en` is 1, `sync_clr` and `par_load` are 0 and `dir_up` is 0, bit i of the new word is old bit i+1, the top bit takes `ser_in_dn`, and the old bit 0 is dropped.
- R6: `word_out` is all zeros from time zero until the first rising edge.
- R7: During a shift, the serial input that belongs to the other direction has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on its rising edge |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| par_load | input | 1 | Parallel load of `par_in` |
| shift_en | input | 1 | Enables a shift when no clear or load is present |
| dir_up | input | 1 | 1 shifts toward the MSB, 0 toward the LSB |
| ser_in_up | input | 1 | New bit 0 during an upward shift |
| ser_in_dn | input | 1 | New top bit during a downward shift |
| par_in | input | WIDTH | Parallel data word |
| word_out | output | WIDTH | Register contents |

## Verification
Directed runs first walk a single one through the word in each direction. This separates the two directions and shows that the dropped end bit does not come back. Upward shifts are then made with the downward serial input held opposite, which shows which serial input each direction takes. Cycles with load and enable both high, and with clear and load both high, check the priority order. A long random stretch covers every control combination against a reference model. Patterns such as 1010, which a wrong shift direction would leave looking right, are caught there.

// File: rtl/bidir_shreg_pkg.sv
package bidir_shreg_pkg;

    // One action per edge, selected by the fixed control priority.
    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_SHIFT_UP = 3'd1,
        OP_SHIFT_DN = 3'd2,
        OP_LOAD     = 3'd3,
        OP_CLEAR    = 3'd4
    } bsr_op_t;

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
    import bidir_shreg_pkg::*;
(
    input  logic    sync_clr,
    input  logic    par_load,
    input  logic    shift_en,
    input  logic    dir_up,
    output bsr_op_t op
);

    // Clear, then load, then enabled shift, then hold.
    always_comb begin
        if (sync_clr)
            op = OP_CLEAR;
        else if (par_load)
            op = OP_LOAD;
        else if (shift_en)
            op = dir_up ? OP_SHIFT_UP : OP_SHIFT_DN;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/bsr_next_value.sv
module bsr_next_value
    import bidir_shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  bsr_op_t          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_v;
    logic [WIDTH-1:0] dn_v;

    // Per-bit neighbour selection for both shift directions.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_up_edge
            assign up_v[i] = ser_in_up;
        end else begin : g_up_mid
            assign up_v[i] = cur[i-1];
        end
        if (i == TOP) begin : g_dn_edge
            assign dn_v[i] = ser_in_dn;
        end else begin : g_dn_mid
            assign dn_v[i] = cur[i+1];
        end
    end

    always_comb begin
        case (op)
            OP_CLEAR:    nxt = '0;
            OP_LOAD:     nxt = par_in;
            OP_SHIFT_UP: nxt = up_v;
            OP_SHIFT_DN: nxt = dn_v;
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg
    import bidir_shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sync_clr,
    input  logic             par_load,
    input  logic             shift_en,
    input  logic             dir_up,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] word_out
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    // Power-up contents are zero through the initial value.
    state_t  st_q = '0;
    state_t  st_d;
    bsr_op_t op;
    logic [WIDTH-1:0] nxt_word;

    bsr_op_decode u_decode (
        .sync_clr (sync_clr),
        .par_load (par_load),
        .shift_en (shift_en),
        .dir_up   (dir_up),
        .op       (op)
    );

    bsr_next_value #(.WIDTH(WIDTH)) u_next (
        .op        (op),
        .cur       (st_q.word),
        .par_in    (par_in),
        .ser_in_up (ser_in_up),
        .ser_in_dn (ser_in_dn),
        .nxt       (nxt_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.word = nxt_word;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word_out = st_q.word;

endmodule

// File: rtl/bidir_shreg_chk.sv
module bidir_shreg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             sync_clr,
    input logic             par_load,
    input logic             shift_en,
    input logic             dir_up,
    input logic             ser_in_up,
    input logic             ser_in_dn,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] word_out
);

    // Set after the first edge so that $past refers to real samples.
    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= 1'b1;

    assert_powerup_zero_R6: assert property (@(posedge clk)
        !seen_q |-> word_out == '0);

    assert_clear_wins_R1: assert property (@(posedge clk) disable iff (!seen_q)
        sync_clr |=> word_out == '0);

    assert_load_copies_R2: assert property (@(posedge clk) disable iff (!seen_q)
        (!sync_clr && par_load) |=> word_out == $past(par_in));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!seen_q)
        (!sync_clr && !par_load && !shift_en) |=> $stable(word_out));

    assert_shift_up_R4: assert property (@(posedge clk) disable iff (!seen_q)
        (!sync_clr && !par_load && shift_en && dir_up) |=>
        word_out == {$past(word_out[WIDTH-2:0]), $past(ser_in_up)});

    assert_shift_dn_R5: assert property (@(posedge clk) disable iff (!seen_q)
        (!sync_clr && !par_load && shift_en && !dir_up) |=>
        word_out == {$past(ser_in_dn), $past(word_out[WIDTH-1:1])});

endmodule

bind bidir_shreg bidir_shreg_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/bidir_shreg_tb_top.sv
`timescale 1ns/1ps
module bidir_shreg_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         sync_clr = 1'b0;
    logic         par_load = 1'b0;
    logic         shift_en = 1'b0;
    logic         dir_up = 1'b0;
    logic         ser_in_up = 1'b0;
    logic         ser_in_dn = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] word_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] model = '0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    bidir_shreg #(.WIDTH(W)) dut_i (
        .clk(clk), .sync_clr(sync_clr), .par_load(par_load), .shift_en(shift_en),
        .dir_up(dir_up), .ser_in_up(ser_in_up), .ser_in_dn(ser_in_dn),
        .par_in(par_in), .word_out(word_out)
    );

    // Driver: applies one cycle of inputs and queues the expected word.
    task automatic drive(input logic c, input logic l, input logic e, input logic d,
                         input logic su, input logic sd, input logic [W-1:0] p,
                         input string tag);
        string t;
        @(negedge clk);
        sync_clr = c; par_load = l; shift_en = e; dir_up = d;
        ser_in_up = su; ser_in_dn = sd; par_in = p;
        if (c)      begin model = '0;                   t = "R1"; end
        else if (l) begin model = p;                    t = "R2"; end
        else if (e && d) begin model = {model[W-2:0], su}; t = "R4"; end
        else if (e) begin model = {sd, model[W-1:1]};   t = "R5"; end
        else        begin                                t = "R3"; end
        if (tag != "") t = tag;
        exp_q.push_back(model);
        tag_q.push_back(t);
    endtask

    // Monitor: compares each result just after the edge that produced it.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (word_out !== e) begin
                errors++;
                $display("FAIL %s: word_out=%b expected=%b", t, word_out, e);
            end
        end
    end

    initial begin
        #1;
        checks++;
        if (word_out !== '0) begin
            errors++;
            $display("FAIL R6: word_out=%b expected=%b", word_out, 4'b0000);
        end
        // Upward walk of a single one, then the top bit drops (R4).
        drive(0,0,1,1,1,0,'0,"R4");
        for (int i = 0; i < 4; i++) drive(0,0,1,1,0,0,'0,"R4");
        // Downward walk from a load (R2, R5).
        drive(0,1,0,0,0,0,4'b1000,"R2");
        for (int i = 0; i < 4; i++) drive(0,0,1,0,0,0,'0,"R5");
        drive(0,0,1,0,1,0,'0,"R5");
        // Opposite serial input ignored (R7).
        drive(0,1,0,0,0,0,4'b1010,"R2");
        drive(0,0,1,1,0,1,'0,"R7");
        drive(0,0,1,0,0,1,'0,"R7");
        drive(0,0,1,1,1,0,'0,"R7");
        // Hold with busy data inputs (R3).
        drive(0,0,0,1,1,1,4'b0101,"R3");
        drive(0,0,0,0,1,1,4'b1111,"R3");
        // Load with enable high, clear with load high (R2, R1).
        drive(0,1,1,1,1,1,4'b0110,"R2");
        drive(1,1,1,0,1,1,4'b1111,"R1");
        drive(0,1,1,0,0,0,4'b1001,"R2");
        drive(1,0,1,1,1,1,4'b1111,"R1");
        // Random mix of every control combination.
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 8) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 4'($urandom), "");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule